// File: doc/BRIEF.md
# Capability List Walker

This block traverses the chain of capability headers held in the configuration space of one bus/device/function. Software or an enumeration engine raises `start` with the function's bus, device and function numbers. The walker then issues word reads on a simple request/acknowledge configuration port. It first fetches the status/command word and only proceeds when the status register says a capability list exists. It then fetches the list head pointer and follows the chain one header at a time.

Every visited header comes out on a valid/ready stream as its byte offset, 8-bit identifier and 16-bit private field. A flag marks headers whose identifier equals a target value. The final header of a walk carries a last marker. The walk ends in one of four ways: a null link, a malformed link, a loop bound, or, when requested, the first header that matches the target. A one-cycle completion pulse reports whether the end was clean or caused by a malformed chain.

Top module: `cap_walker`

## Requirements
- R1: After `start`, the first read is at offset 0x04. If bit 20 of that word (status bit 4) is 0, the walk completes with no entries and `doneErr` = 0.
- R2: Otherwise the second read is at offset 0x34, and the head pointer is its bits [7:0] ANDed with 0xFC. A head of 0 completes the walk with no entries and `doneErr` = 0.
- R3: For each header, the walker reads one word at the current offset. It emits that offset on `entOffset`, bits [7:0] on `entId` and bits [31:16] on `entPriv`. Bits [15:8] give the offset of the next header.
- R4: A next pointer of 0 makes the current entry the final one, with `entLast` = 1. The walk then completes with `doneErr` = 0. No entry other than the final one has `entLast` = 1.
- R5: A next pointer that is nonzero and either below 0x40 or not a multiple of 4 is never followed. The current entry is emitted as final, and `doneErr` = 1. A nonzero head below 0x40 completes the walk with no entries and `doneErr` = 1.
- R6: `entMatch` is 1 exactly when `entId` equals parameter `TARGET_ID` (default 0x09).
- R7: When `stopOnMatch` was 1 at `start`, the first matching entry is final and the walk completes with `doneErr` = 0, whatever its next pointer holds.
- R8: A walk emits at most `MAX_ENTRIES` (default 48) entries. If entry number `MAX_ENTRIES` has a nonzero next pointer, that entry is final and `doneErr` = 1.
- R9: While `entValid` is 1 and `entReady` is 0, `entValid` stays 1 and the entry fields stay stable.
- R10: `cfgReq` holds with a stable `cfgOff` until `cfgAck`. Every offset is word aligned. `cfgBus`/`cfgDev`/`cfgFn` equal the values captured at `start`.
- R11: After reset the block is idle, with `busy`, `cfgReq`, `entValid` and `donePulse` all 0. `donePulse` lasts one cycle and is followed by idle. A `start` raised while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| stopOnMatch | input | 1 | End at first entry matching TARGET_ID |
| busIn | input | 8 | Bus number of the function |
| devIn | input | 5 | Device number |
| fnIn | input | 3 | Function number |
| busy | output | 1 | Walk in progress |
| cfgReq | output | 1 | Configuration read request |
| cfgBus | output | 8 | Bus number of the request |
| cfgDev | output | 5 | Device number of the request |
| cfgFn | output | 3 | Function number of the request |
| cfgOff | output | 8 | Byte offset of the requested word |
| cfgAck | input | 1 | Read data valid, completes the request |
| cfgRdata | input | 32 | Read data |
| entValid | output | 1 | Entry available |
| entReady | input | 1 | Consumer accepts entry |
| entOffset | output | 8 | Offset of the entry |
| entId | output | 8 | Capability identifier |
| entPriv | output | 16 | Upper 16 header bits |
| entMatch | output | 1 | Identifier equals TARGET_ID |
| entLast | output | 1 | Final entry of the walk |
| donePulse | output | 1 | Walk completed (one cycle) |
| doneErr | output | 1 | Walk ended on a malformed chain (valid with donePulse) |

## Verification
A corrupted current-offset register shows on the very next `cfgOff` request. It then shows as a wrong `entOffset` on the entry that follows, about two cycles after the acknowledge. A wrong terminate or error decision at entry load shows as a misplaced `entLast`. It can also show as an extra or missing entry, or a wrong `doneErr` on the completion pulse one cycle after the final handshake. A lost hold under backpressure shows as changed entry fields in the first stalled cycle. A runaway counter is caught by comparing the number of handshakes against the bound.

// File: rtl/capw_pkg.sv
package capw_pkg;
  localparam int OFF_W   = 8;
  localparam int DATA_W  = 32;
  localparam logic [OFF_W-1:0] STAT_OFF = 8'h04;
  localparam logic [OFF_W-1:0] HEAD_OFF = 8'h34;
  localparam logic [OFF_W-1:0] MIN_PTR  = 8'h40;
  localparam int CAP_BIT = 20;

  typedef enum logic [1:0] {OFF_STAT, OFF_HEAD, OFF_ENTRY} offSel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STAT, ST_HEAD, ST_ENTRY, ST_EMIT, ST_DONE
  } walkState_e;

  typedef struct packed {
    logic    captureReq;
    logic    loadHead;
    logic    loadEntry;
    logic    advance;
    logic    markErr;
    offSel_e offSel;
  } ctlStrobe_t;
endpackage

// File: rtl/capw_dpath.sv
module capw_dpath
  import capw_pkg::*;
#(
  parameter int MAX_ENTRIES = 48,
  parameter logic [7:0] TARGET_ID = 8'h09
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic              stopOnMatch,
  input  logic [7:0]        busIn,
  input  logic [4:0]        devIn,
  input  logic [2:0]        fnIn,
  input  logic [DATA_W-1:0] cfgRdata,
  output logic [7:0]        cfgBus,
  output logic [4:0]        cfgDev,
  output logic [2:0]        cfgFn,
  output logic [OFF_W-1:0]  cfgOff,
  output logic              capPresent,
  output logic              headZero,
  output logic              headBad,
  output logic [OFF_W-1:0]  entOffset,
  output logic [7:0]        entId,
  output logic [15:0]       entPriv,
  output logic              entMatch,
  output logic              entLast,
  output logic              errFlag
);
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_ENTRIES - 1);

  logic [7:0]        busQ;
  logic [4:0]        devQ;
  logic [2:0]        fnQ;
  logic              stopQ;
  logic [OFF_W-1:0]  curOff;
  logic [DATA_W-1:0] entWord;
  logic [CNT_W-1:0]  entCount;
  logic              lastQ;
  logic              errQ;

  function automatic logic ptrBad(input logic [OFF_W-1:0] p);
    return (p < MIN_PTR) || (p[1:0] != 2'b00);
  endfunction

  logic [OFF_W-1:0] headPtr, nextPtr;
  logic matchHit, stopHit, nextZero, nextBad, boundHit, endHere, errHere;

  always_comb begin
    headPtr    = cfgRdata[7:0] & 8'hFC;
    nextPtr    = cfgRdata[15:8];
    capPresent = cfgRdata[CAP_BIT];
    headZero   = (headPtr == '0);
    headBad    = !headZero && (headPtr < MIN_PTR);
    matchHit   = (cfgRdata[7:0] == TARGET_ID);
    stopHit    = stopQ && matchHit;
    nextZero   = (nextPtr == '0);
    nextBad    = !nextZero && ptrBad(nextPtr);
    boundHit   = (entCount == LAST_IDX);
    endHere    = nextZero || nextBad || boundHit || stopHit;
    errHere    = !stopHit && !nextZero && (nextBad || boundHit);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busQ <= '0; devQ <= '0; fnQ <= '0; stopQ <= 1'b0;
      curOff <= '0; entWord <= '0; entCount <= '0;
      lastQ <= 1'b0; errQ <= 1'b0;
    end else begin
      if (ctl.captureReq) begin
        busQ     <= busIn;
        devQ     <= devIn;
        fnQ      <= fnIn;
        stopQ    <= stopOnMatch;
        entCount <= '0;
        lastQ    <= 1'b0;
        errQ     <= 1'b0;
      end
      if (ctl.markErr) errQ <= 1'b1;
      if (ctl.loadHead) curOff <= headPtr;
      if (ctl.loadEntry) begin
        entWord  <= cfgRdata;
        entCount <= entCount + CNT_W'(1);
        lastQ    <= endHere;
        if (errHere) errQ <= 1'b1;
      end
      if (ctl.advance) curOff <= entWord[15:8];
    end
  end

  always_comb begin
    unique case (ctl.offSel)
      OFF_STAT:  cfgOff = STAT_OFF;
      OFF_HEAD:  cfgOff = HEAD_OFF;
      default:   cfgOff = curOff;
    endcase
  end

  assign cfgBus    = busQ;
  assign cfgDev    = devQ;
  assign cfgFn     = fnQ;
  assign entOffset = curOff;
  assign entId     = entWord[7:0];
  assign entPriv   = entWord[31:16];
  assign entMatch  = (entWord[7:0] == TARGET_ID);
  assign entLast   = lastQ;
  assign errFlag   = errQ;
endmodule

// File: rtl/capw_ctrl.sv
module capw_ctrl
  import capw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       cfgAck,
  input  logic       capPresent,
  input  logic       headZero,
  input  logic       headBad,
  input  logic       lastFlag,
  input  logic       entReady,
  output ctlStrobe_t ctl,
  output logic       cfgReq,
  output logic       entValid,
  output logic       donePulse,
  output logic       busy
);
  walkState_e st, stNext;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    ctl       = '0;
    stNext    = st;
    cfgReq    = 1'b0;
    entValid  = 1'b0;
    donePulse = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin
        ctl.captureReq = 1'b1;
        stNext = ST_STAT;
      end
      ST_STAT: begin
        cfgReq = 1'b1;
        ctl.offSel = OFF_STAT;
        if (cfgAck) stNext = capPresent ? ST_HEAD : ST_DONE;
      end
      ST_HEAD: begin
        cfgReq = 1'b1;
        ctl.offSel = OFF_HEAD;
        if (cfgAck) begin
          if (headZero) stNext = ST_DONE;
          else if (headBad) begin
            ctl.markErr = 1'b1;
            stNext = ST_DONE;
          end else begin
            ctl.loadHead = 1'b1;
            stNext = ST_ENTRY;
          end
        end
      end
      ST_ENTRY: begin
        cfgReq = 1'b1;
        ctl.offSel = OFF_ENTRY;
        if (cfgAck) begin
          ctl.loadEntry = 1'b1;
          stNext = ST_EMIT;
        end
      end
      ST_EMIT: begin
        entValid = 1'b1;
        ctl.offSel = OFF_ENTRY;
        if (entReady) begin
          if (lastFlag) stNext = ST_DONE;
          else begin
            ctl.advance = 1'b1;
            stNext = ST_ENTRY;
          end
        end
      end
      default: begin
        donePulse = 1'b1;
        stNext = ST_IDLE;
      end
    endcase
  end

  assign busy = (st != ST_IDLE);
endmodule

// File: rtl/cap_walker.sv
module cap_walker
  import capw_pkg::*;
#(
  parameter int MAX_ENTRIES = 48,
  parameter logic [7:0] TARGET_ID = 8'h09
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        stopOnMatch,
  input  logic [7:0]  busIn,
  input  logic [4:0]  devIn,
  input  logic [2:0]  fnIn,
  output logic        busy,
  output logic        cfgReq,
  output logic [7:0]  cfgBus,
  output logic [4:0]  cfgDev,
  output logic [2:0]  cfgFn,
  output logic [7:0]  cfgOff,
  input  logic        cfgAck,
  input  logic [31:0] cfgRdata,
  output logic        entValid,
  input  logic        entReady,
  output logic [7:0]  entOffset,
  output logic [7:0]  entId,
  output logic [15:0] entPriv,
  output logic        entMatch,
  output logic        entLast,
  output logic        donePulse,
  output logic        doneErr
);
  ctlStrobe_t ctl;
  logic capPresent, headZero, headBad;

  capw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgAck(cfgAck),
    .capPresent(capPresent), .headZero(headZero), .headBad(headBad),
    .lastFlag(entLast), .entReady(entReady), .ctl(ctl),
    .cfgReq(cfgReq), .entValid(entValid), .donePulse(donePulse), .busy(busy)
  );

  capw_dpath #(.MAX_ENTRIES(MAX_ENTRIES), .TARGET_ID(TARGET_ID)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stopOnMatch(stopOnMatch),
    .busIn(busIn), .devIn(devIn), .fnIn(fnIn), .cfgRdata(cfgRdata),
    .cfgBus(cfgBus), .cfgDev(cfgDev), .cfgFn(cfgFn), .cfgOff(cfgOff),
    .capPresent(capPresent), .headZero(headZero), .headBad(headBad),
    .entOffset(entOffset), .entId(entId), .entPriv(entPriv),
    .entMatch(entMatch), .entLast(entLast), .errFlag(doneErr)
  );
endmodule

// File: rtl/capw_chk.sv
module capw_chk #(
  parameter int MAX_ENTRIES = 48
) (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        cfgReq,
  input logic [7:0]  cfgOff,
  input logic        cfgAck,
  input logic        entValid,
  input logic        entReady,
  input logic [7:0]  entOffset,
  input logic [7:0]  entId,
  input logic [15:0] entPriv,
  input logic        entLast,
  input logic        donePulse
);
  localparam int CNT_W = $clog2(MAX_ENTRIES + 2);
  logic [CNT_W-1:0] hsCnt;

  always_ff @(posedge clk) begin
    if (!rstN) hsCnt <= '0;
    else if (start && !busy) hsCnt <= '0;
    else if (entValid && entReady) hsCnt <= hsCnt + CNT_W'(1);
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    entValid && !entReady |=> entValid && $stable(entOffset) && $stable(entId)
      && $stable(entPriv) && $stable(entLast));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq && !cfgAck |=> cfgReq && $stable(cfgOff));

  assert_aligned_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq |-> cfgOff[1:0] == 2'b00);

  assert_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq && cfgOff != 8'h04 && cfgOff != 8'h34 |-> cfgOff >= 8'h40);

  assert_last_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    entValid && entReady && entLast |=> donePulse);

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse && !busy);

  assert_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cfgReq, entValid, donePulse}));

  assert_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    hsCnt <= CNT_W'(MAX_ENTRIES));
endmodule

bind cap_walker capw_chk #(.MAX_ENTRIES(MAX_ENTRIES)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .cfgReq(cfgReq),
  .cfgOff(cfgOff), .cfgAck(cfgAck), .entValid(entValid), .entReady(entReady),
  .entOffset(entOffset), .entId(entId), .entPriv(entPriv), .entLast(entLast),
  .donePulse(donePulse)
);

// File: tb/cap_walker_tb.sv
module cap_walker_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, start = 1'b0, stopOnMatch = 1'b0;
  logic [7:0] busIn = 8'h12;
  logic [4:0] devIn = 5'h0B;
  logic [2:0] fnIn = 3'h5;
  logic busy, cfgReq, cfgAck, entValid, entReady, entMatch, entLast, donePulse, doneErr;
  logic [7:0] cfgBus, cfgOff, entOffset, entId;
  logic [4:0] cfgDev;
  logic [2:0] cfgFn;
  logic [31:0] cfgRdata;
  logic [15:0] entPriv;

  cap_walker u_dut (.*);

  logic [31:0] cfgMem [64];
  always_ff @(posedge clk) begin
    if (!rstN) begin cfgAck <= 1'b0; cfgRdata <= '0; end
    else begin
      cfgAck   <= cfgReq && !cfgAck;
      cfgRdata <= cfgMem[cfgOff[7:2]];
    end
  end

  int nTests = 0, nFail = 0;
  logic finished = 1'b0;

  task automatic chk(input logic ok, input string tag, input string what, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic             cap;
    logic [7:0]       head;
    logic             stop;
    logic [3:0][7:0]  ids;
    logic [3:0][7:0]  nxt;
    logic [2:0]       expCnt;
    logic             expErr;
  } scen_t;

  localparam int NSCN = 11;
  localparam scen_t SCN [NSCN] = '{
    '{1'b0, 8'h40, 1'b0, 32'h00000001, 32'h00000000, 3'd0, 1'b0}, // R1 flag clear
    '{1'b1, 8'h00, 1'b0, 32'h00000000, 32'h00000000, 3'd0, 1'b0}, // R2 null head
    '{1'b1, 8'h40, 1'b0, 32'h11100501, 32'h00006050, 3'd3, 1'b0}, // R4 normal chain
    '{1'b1, 8'h48, 1'b0, 32'h00000201, 32'h00000052, 3'd1, 1'b1}, // R5 unaligned link
    '{1'b1, 8'h80, 1'b0, 32'h00000007, 32'h0000003C, 3'd1, 1'b1}, // R5 low link
    '{1'b1, 8'h40, 1'b1, 32'h00050901, 32'h00004844, 3'd2, 1'b0}, // R7 stop on match
    '{1'b1, 8'h40, 1'b0, 32'h00050901, 32'h00004844, 3'd3, 1'b0}, // R6 match no stop
    '{1'b1, 8'h43, 1'b0, 32'h0000000A, 32'h00000000, 3'd1, 1'b0}, // R2 head masking
    '{1'b1, 8'h20, 1'b0, 32'h00000000, 32'h00000000, 3'd0, 1'b1}, // R5 low head
    '{1'b1, 8'h40, 1'b0, 32'h09080706, 32'h00C080FC, 3'd4, 1'b0}, // R3 four entries
    '{1'b1, 8'h40, 1'b1, 32'h00000009, 32'h00000041, 3'd1, 1'b0}  // R7 match before bad link
  };

  logic [7:0]  recOff [64];
  logic [7:0]  recId [64];
  logic [15:0] recPriv [64];
  logic        recMatch [64];
  logic        recLast [64];
  int recCnt;
  logic bdfOk, stableOk, doneSeen, errSeen;

  task automatic clearMem();
    for (int i = 0; i < 64; i++) cfgMem[i] = 32'h0;
  endtask

  task automatic setHeader(input logic cap, input logic [7:0] head);
    cfgMem[1]  = {16'h0200 | {11'h0, cap, 4'h0}, 16'h0007};
    cfgMem[13] = {24'h5A5A5A, head};
  endtask

  task automatic runWalk(input logic stp, input int stall, input logic midStart);
    int cyc;
    int st;
    logic snap;
    logic [7:0] sOff, sId;
    logic [15:0] sPriv;
    logic [7:0] bus0;
    logic [4:0] dev0;
    logic [2:0] fn0;
    recCnt = 0; bdfOk = 1'b1; stableOk = 1'b1; doneSeen = 1'b0; errSeen = 1'b0;
    st = stall; snap = 1'b0; sOff = '0; sId = '0; sPriv = '0;
    bus0 = busIn; dev0 = devIn; fn0 = fnIn;
    @(negedge clk);
    stopOnMatch = stp; entReady = (stall == 0); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!doneSeen && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (cfgReq && (cfgBus != bus0 || cfgDev != dev0 || cfgFn != fn0)) bdfOk = 1'b0;
      if (entValid && st > 0) begin
        if (!snap) begin
          sOff = entOffset; sId = entId; sPriv = entPriv; snap = 1'b1;
        end else if (entOffset != sOff || entId != sId || entPriv != sPriv) stableOk = 1'b0;
        entReady = 1'b0;
        st--;
      end else entReady = 1'b1;
      if (entValid && entReady) begin
        if (snap && recCnt == 0 && (entOffset != sOff || entId != sId || entPriv != sPriv))
          stableOk = 1'b0;
        if (recCnt < 64) begin
          recOff[recCnt] = entOffset; recId[recCnt] = entId; recPriv[recCnt] = entPriv;
          recMatch[recCnt] = entMatch; recLast[recCnt] = entLast;
        end
        recCnt++;
      end
      if (donePulse) begin doneSeen = 1'b1; errSeen = doneErr; end
      if (midStart && cyc == 3) begin start = 1'b1; busIn = 8'h77; end
      else start = 1'b0;
    end
    start = 1'b0; entReady = 1'b1;
    chk(doneSeen, "R11", "completion seen", int'(doneSeen), 1);
    @(negedge clk);
    chk(!donePulse && !busy, "R11", "pulse one cycle then idle", int'({donePulse, busy}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    entReady = 1'b1;
    clearMem();
    repeat (3) @(negedge clk);
    chk(!busy && !cfgReq && !entValid && !donePulse, "R11", "reset idle",
        int'({busy, cfgReq, entValid, donePulse}), 0);
    rstN = 1'b1;

    for (int s = 0; s < NSCN; s++) begin
      scen_t v;
      logic [7:0] o;
      string tag;
      v = SCN[s];
      clearMem();
      setHeader(v.cap, v.head);
      o = v.head & 8'hFC;
      for (int k = 0; k < 4; k++) begin
        if (o < 8'h40 || o[1:0] != 2'b00) break;
        cfgMem[o[7:2]] = {8'hA5, o, v.nxt[k], v.ids[k]};
        o = v.nxt[k];
      end
      runWalk(v.stop, 0, 1'b0);
      tag = !v.cap ? "R1" : (v.head == 8'h00) ? "R2" : v.expErr ? "R5" : v.stop ? "R7" : "R4";
      chk(recCnt == int'(v.expCnt), tag, $sformatf("scenario %0d entry count", s), recCnt, int'(v.expCnt));
      chk(errSeen == v.expErr, tag, $sformatf("scenario %0d error flag", s), int'(errSeen), int'(v.expErr));
      chk(bdfOk, "R10", $sformatf("scenario %0d request address", s), int'(bdfOk), 1);
      o = v.head & 8'hFC;
      for (int k = 0; k < int'(v.expCnt) && k < recCnt; k++) begin
        chk(recOff[k] == o, "R3", $sformatf("s%0d e%0d offset", s, k), recOff[k], o);
        chk(recId[k] == v.ids[k], "R3", $sformatf("s%0d e%0d id", s, k), recId[k], v.ids[k]);
        chk(recPriv[k] == {8'hA5, o}, "R3", $sformatf("s%0d e%0d priv", s, k), recPriv[k], {8'hA5, o});
        chk(recMatch[k] == (v.ids[k] == 8'h09), "R6", $sformatf("s%0d e%0d match", s, k),
            int'(recMatch[k]), int'(v.ids[k] == 8'h09));
        chk(recLast[k] == (k == int'(v.expCnt) - 1), "R4", $sformatf("s%0d e%0d last", s, k),
            int'(recLast[k]), int'(k == int'(v.expCnt) - 1));
        o = v.nxt[k];
      end
    end

    // R8: self-referencing header loops until the entry bound
    clearMem();
    setHeader(1'b1, 8'h40);
    cfgMem[16] = {8'hA5, 8'h40, 8'h40, 8'h01};
    runWalk(1'b0, 0, 1'b0);
    chk(recCnt == 48, "R8", "loop entry count", recCnt, 48);
    chk(errSeen, "R8", "loop error flag", int'(errSeen), 1);
    chk(recLast[47] && !recLast[46], "R8", "last on bound entry", int'({recLast[46], recLast[47]}), 1);

    // R9: backpressure on the first entry of a three-entry chain
    clearMem();
    setHeader(1'b1, 8'h40);
    cfgMem[16] = {8'hA5, 8'h40, 8'h50, 8'h01};
    cfgMem[20] = {8'hA5, 8'h50, 8'h60, 8'h05};
    cfgMem[24] = {8'hA5, 8'h60, 8'h00, 8'h10};
    runWalk(1'b0, 6, 1'b0);
    chk(stableOk, "R9", "entry stable while stalled", int'(stableOk), 1);
    chk(recCnt == 3, "R9", "no entry lost or duplicated", recCnt, 3);
    chk(recOff[0] == 8'h40 && recId[0] == 8'h01, "R9", "first entry after stall",
        int'({recOff[0], recId[0]}), 32'h4001);

    // R11: start raised mid-walk with another bus number is ignored
    runWalk(1'b0, 0, 1'b1);
    chk(recCnt == 3, "R11", "restart ignored count", recCnt, 3);
    chk(bdfOk, "R11", "restart ignored address", int'(bdfOk), 1);
    busIn = 8'h12;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule